// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Registers

This block holds the software-visible registers of a PCI message-signalled interrupt capability. Software reaches it through a dword-wide register port with byte enables. The dword index on that port counts from the first byte of the capability. Three elaboration parameters shape it: the number of vectors (a power of two from 1 to 32), whether a 64-bit message address is supported, and whether per-vector masking is present. The capability length and the per-bit write masks follow from those three choices.

The live enable, vector-count setting, message address, message data, vector mask and pending bits are driven out continuously to a separate dispatch block. That dispatch block also loads the pending register through a dedicated port. Whenever a write inside the capability leaves the function enabled, a one-cycle pulse tells the legacy wire-interrupt logic to drop its request. An enabled vector-count setting larger than the advertised capability is pulled back to the advertised value.

Top module: `msi_cap_regs`

## Requirements
- R1: The capability spans 10 bytes in the plain form, 14 with 64-bit addressing, 20 with masking only and 24 with both. Bytes past that length read as zero, and writes to them change nothing and raise no pulse.
- R2: Dword 0 reads capability ID 0x05 in bits 7:0 and zero in bits 15:8. The control word sits in bits 31:16. Within the control word, bit 0 is the enable, bits 3:1 hold the read-only advertised count log2(N), bits 6:4 hold the requested count, bit 7 is the read-only 64-bit flag and bit 8 is the read-only masking flag.
- R3: In the control word, only the enable bit and the requested-count field respond to writes, and each byte lane is written only when its byte enable is set.
- R4: The low message address is at dword 1. Its bits 1:0 always read zero, and every other bit is writable under byte enables.
- R5: In the 64-bit form, dword 2 holds the fully writable upper address, and the 16-bit message data sits in the low half of dword 3. In the 32-bit form, the message data sits in the low half of dword 2. The upper half of the data dword reads zero.
- R6: The mask register follows the data dword. Only its bits 0 to N-1 can be written, and its higher bits read zero.
- R7: When a write leaves the enable set and the requested count is above the advertised count, the requested count becomes the advertised count. When the enable is clear after the write, no clamp is applied.
- R8: After a write that touches the capability and leaves the enable set, `intx_deassert` is high for exactly the next cycle. No other event raises it.
- R9: Reset clears the enable, the requested count, both address words, the data, the mask and the pending bits.
- R10: The pending register follows the mask register. Software writes do not change it. A pulse on `pend_load` replaces it with `pend_val` restricted to bits 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_addr | input | 3 | Dword index within the capability |
| acc_be | input | 4 | Byte enables for the write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the dword at acc_addr |
| pend_load | input | 1 | Load strobe from the dispatch logic |
| pend_val | input | 32 | New pending bits |
| msi_en | output | 1 | Enable bit |
| mme | output | 3 | Requested vector count, log2 |
| msg_addr | output | 64 | Message address (upper half zero in the 32-bit form) |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask |
| pending | output | 32 | Pending bits |
| intx_deassert | output | 1 | One-cycle legacy interrupt release pulse |

## Verification
The checks assume that `acc_wr` and `pend_load` only change register state on a clock edge while reset is released. They also assume the read address is held steady long enough for the combinational read data to settle. The stimulus drives every input on the falling edge, so each write or load is seen by exactly one rising edge. The stimulus holds each read address for a nanosecond before sampling. The dword index is always kept within its three bits. Index 6 and index 7 are exercised on purpose, as addresses past the end of the capability.

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter int NUM_VEC     = 8,
  parameter int ADDR64      = 1,
  parameter int VEC_MASKING = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic [2:0]  acc_addr,
  input  logic [3:0]  acc_be,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  input  logic        pend_load,
  input  logic [31:0] pend_val,
  output logic        msi_en,
  output logic [2:0]  mme,
  output logic [63:0] msg_addr,
  output logic [15:0] msg_data,
  output logic [31:0] vec_mask,
  output logic [31:0] pending,
  output logic        intx_deassert
);

  localparam int          MMC     = $clog2(NUM_VEC);
  localparam logic [2:0]  MMC_F   = 3'(MMC);
  localparam int          CAP_LEN = (ADDR64 != 0) ? ((VEC_MASKING != 0) ? 24 : 14)
                                                  : ((VEC_MASKING != 0) ? 20 : 10);
  localparam logic [2:0]  DW_DATA = (ADDR64 != 0) ? 3'd3 : 3'd2;
  localparam logic [2:0]  DW_MASK = DW_DATA + 3'd1;
  localparam logic [2:0]  DW_PEND = DW_DATA + 3'd2;
  localparam logic [31:0] VMASK   = 32'hFFFF_FFFF >> (32 - NUM_VEC);
  localparam logic        HAS64   = (ADDR64 != 0);
  localparam logic        HASMSK  = (VEC_MASKING != 0);

  logic        en_q, intx_q;
  logic [2:0]  mme_q;
  logic [29:0] alo_q;
  logic [31:0] ahi_q, mask_q, pend_q;
  logic [15:0] data_q;

  logic [3:0]  in_cap;
  logic [31:0] lane_m, cur, wm, nxt;
  logic [15:0] ctrl;
  logic        hit, en_n;
  logic [2:0]  mme_n;

  always_comb begin
    for (int b = 0; b < 4; b++)
      in_cap[b] = ({3'd0, acc_addr, 2'(b)} < 8'(CAP_LEN));
  end

  assign lane_m = {{8{in_cap[3]}}, {8{in_cap[2]}}, {8{in_cap[1]}}, {8{in_cap[0]}}};
  assign ctrl   = {7'd0, HASMSK, HAS64, mme_q, MMC_F, en_q};

  always_comb begin
    cur = '0;
    wm  = '0;
    if (acc_addr == 3'd0) begin
      cur = {ctrl, 8'h00, 8'h05};
      wm  = 32'h0071_0000;
    end else if (acc_addr == 3'd1) begin
      cur = {alo_q, 2'b00};
      wm  = 32'hFFFF_FFFC;
    end else if (HAS64 && acc_addr == 3'd2) begin
      cur = ahi_q;
      wm  = 32'hFFFF_FFFF;
    end else if (acc_addr == DW_DATA) begin
      cur = {16'h0, data_q};
      wm  = 32'h0000_FFFF;
    end else if (HASMSK && acc_addr == DW_MASK) begin
      cur = mask_q;
      wm  = VMASK;
    end else if (HASMSK && acc_addr == DW_PEND) begin
      cur = pend_q;
    end
  end

  assign acc_rdata = cur & lane_m;

  logic [31:0] be_m;
  assign be_m = {{8{acc_be[3]}}, {8{acc_be[2]}}, {8{acc_be[1]}}, {8{acc_be[0]}}};
  assign nxt  = (cur & ~(wm & be_m & lane_m)) | (acc_wdata & wm & be_m & lane_m);
  assign hit  = acc_wr && |(acc_be & in_cap);

  always_comb begin
    en_n  = en_q;
    mme_n = mme_q;
    if (acc_wr && acc_addr == 3'd0) begin
      en_n  = nxt[16];
      mme_n = nxt[22:20];
    end
    if (hit && en_n && mme_n > MMC_F)
      mme_n = MMC_F;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mme_q  <= 3'd0;
      alo_q  <= '0;
      ahi_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      intx_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      mme_q  <= mme_n;
      intx_q <= hit && en_n;
      if (acc_wr && acc_addr == 3'd1)
        alo_q <= nxt[31:2];
      if (HAS64 && acc_wr && acc_addr == 3'd2)
        ahi_q <= nxt;
      if (acc_wr && acc_addr == DW_DATA)
        data_q <= nxt[15:0];
      if (HASMSK && acc_wr && acc_addr == DW_MASK)
        mask_q <= nxt;
      if (HASMSK && pend_load)
        pend_q <= pend_val & VMASK;
    end
  end

  assign msi_en        = en_q;
  assign mme           = mme_q;
  assign msg_addr      = {ahi_q, alo_q, 2'b00};
  assign msg_data      = data_q;
  assign vec_mask      = mask_q;
  assign pending       = pend_q;
  assign intx_deassert = intx_q;

endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
  parameter int NUM_VEC = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_wr,
  input logic [2:0]  acc_addr,
  input logic [31:0] acc_rdata,
  input logic        pend_load,
  input logic        msi_en,
  input logic [2:0]  mme,
  input logic [31:0] vec_mask,
  input logic [31:0] pending,
  input logic        intx_deassert
);
  localparam logic [2:0]  MMC_F = 3'($clog2(NUM_VEC));
  localparam logic [31:0] VMASK = 32'hFFFF_FFFF >> (32 - NUM_VEC);

  // R7
  enabled_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> mme <= MMC_F);

  // R8
  intx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> (msi_en && $past(acc_wr)));

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable({msi_en, mme}));

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_load |=> $stable(pending));

  // R6
  mask_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mask & ~VMASK) == 32'd0);

  // R2
  mmc_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr == 3'd0 |-> acc_rdata[19:17] == MMC_F);
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
  .acc_rdata(acc_rdata), .pend_load(pend_load), .msi_en(msi_en), .mme(mme),
  .vec_mask(vec_mask), .pending(pending), .intx_deassert(intx_deassert)
);

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        pend_load = 1'b0;
  logic [31:0] pend_val = '0;
  logic        msi_en, intx_deassert;
  logic [2:0]  mme;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [31:0] vec_mask, pending;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  msi_cap_regs u_dut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pend_load(pend_load), .pend_val(pend_val), .msi_en(msi_en), .mme(mme),
    .msg_addr(msg_addr), .msg_data(msg_data), .vec_mask(vec_mask),
    .pending(pending), .intx_deassert(intx_deassert)
  );

  // {addr, be, wdata, expected read}
  localparam logic [70:0] VEC [12] = '{
    {3'd1, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFC},  // R4
    {3'd1, 4'h1, 32'h0000_0012, 32'hFFFF_FF10},  // R4
    {3'd2, 4'hF, 32'h1234_5678, 32'h1234_5678},  // R5
    {3'd3, 4'hF, 32'hABCD_BEEF, 32'h0000_BEEF},  // R5
    {3'd4, 4'hF, 32'hFFFF_FFFF, 32'h0000_00FF},  // R6
    {3'd4, 4'hF, 32'h0000_00A5, 32'h0000_00A5},  // R6
    {3'd5, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R10
    {3'd0, 4'hF, 32'hFFFF_FFFF, 32'h01B7_0005},  // R7
    {3'd0, 4'hF, 32'h0050_0000, 32'h01D6_0005},  // R7
    {3'd0, 4'hF, 32'h0021_0000, 32'h01A7_0005},  // R3
    {3'd6, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R1
    {3'd0, 4'h3, 32'hFFFF_FFFF, 32'h01A7_0005}   // R3
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_be = be; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    acc_addr = a;
    #1;
    check(tag, {32'd0, acc_rdata}, {32'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 R2: values held in reset
    rd("R2 ctrl at reset", 3'd0, 32'h0186_0005);
    for (int i = 1; i < 6; i++) rd("R9 reset dword", 3'(i), 32'd0);
    check("R9 enable at reset", {63'd0, msi_en}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][70:68], VEC[i][67:64], VEC[i][63:32]);
      rd("table vector R1..R10", VEC[i][70:68], VEC[i][31:0]);
    end

    check("R5 msg_addr out", msg_addr, 64'h1234_5678_FFFF_FF10);
    check("R5 msg_data out", {48'd0, msg_data}, 64'h0000_0000_0000_BEEF);
    check("R6 vec_mask out", {32'd0, vec_mask}, 64'h0000_0000_0000_00A5);
    check("R7 mme out", {61'd0, mme}, 64'd2);

    // R8 pulse after a write that leaves enable set
    wr(3'd3, 4'hF, 32'h0000_1111);
    check("R8 pulse high", {63'd0, intx_deassert}, 64'd1);
    @(negedge clk);
    check("R8 pulse one cycle", {63'd0, intx_deassert}, 64'd0);
    // R1 write past the end: no pulse
    wr(3'd7, 4'hF, 32'hFFFF_FFFF);
    check("R1 outside no pulse", {63'd0, intx_deassert}, 64'd0);
    // R8 disabling write: no pulse
    wr(3'd0, 4'hF, 32'h0000_0000);
    check("R8 disabled no pulse", {63'd0, intx_deassert}, 64'd0);

    // R10 pending load restricted to N bits
    @(negedge clk);
    pend_load = 1'b1; pend_val = 32'hFFFF_FF3C;
    @(negedge clk);
    pend_load = 1'b0;
    check("R10 pending out", {32'd0, pending}, 64'h3C);
    rd("R10 pending read", 3'd5, 32'h0000_003C);
    wr(3'd5, 4'hF, 32'h0000_0000);
    rd("R10 pending ignores write", 3'd5, 32'h0000_003C);

    // R9 reset mid-run
    wr(3'd0, 4'hF, 32'h0031_0000);
    #2 rst_n = 1'b0;
    #1;
    check("R9 enable cleared", {63'd0, msi_en}, 64'd0);
    check("R9 mme cleared", {61'd0, mme}, 64'd0);
    check("R9 addr cleared", msg_addr, 64'd0);
    check("R9 data cleared", {48'd0, msg_data}, 64'd0);
    check("R9 mask cleared", {32'd0, vec_mask}, 64'd0);
    check("R9 pending cleared", {32'd0, pending}, 64'd0);
    rd("R9 R2 ctrl after reset", 3'd0, 32'h0186_0005);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule